// File: doc/BRIEF.md
# Serial CRC Appender

This block computes cyclic redundancy checksums over a one-bit stream and inserts each checksum into the stream directly after the bits it covers. An incoming frame is cut into subframes of a fixed length. The division register restarts from its configured start value at the beginning of every subframe. After the last bit of a subframe, the block holds off further input, shifts out the finished checksum, and then accepts the next subframe.

The checksum width, the polynomial and its start value are fixed at elaboration, as are the division method and the final mask. The division method is either direct feed or zero-augmented flush. Two reflections are also set at elaboration. One reverses the bit order inside each byte on the way into the divider. The other reverses the finished checksum before the mask is applied.

Both edges are valid/ready streams of single bits, and the output carries a frame end flag. The block sits after a bit serialiser and ahead of a line coder or framer.

Top module: `serial_crc_appender`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `out_last` are 0, and `in_ready` is 1.
- R2: Every accepted bit leaves on `out_bit` unchanged and in order. Each group of `SUB_LEN` bits is followed by exactly `POLY_W` checksum bits, emitted most significant bit first. A frame of C subframes therefore yields C·(`SUB_LEN`+`POLY_W`) output bits.
- R3: With `DIRECT`=0, the raw checksum is the remainder of (I·x^(n+W) + M·x^W) modulo G. Here G = x^W + `POLY`, n = `SUB_LEN`, I is the start value and M is the subframe polynomial, whose first bit is the highest power. I is reloaded for every subframe.
- R4: With `DIRECT`=1, the raw checksum is the remainder of (I·x^n + M·x^W) modulo G, using the same definitions as R3.
- R5: With `REFIN`=1, the bits of each consecutive 8-bit group of a subframe enter the division in reverse order. The bits forwarded on `out_bit` keep their arrival order.
- R6: With `REFOUT`=1, the raw checksum is reversed end to end before the final mask. The final mask is XORed in last. A zero mask leaves the checksum unchanged.
- R7: When `INIT_SCALAR` or `XOR_SCALAR` is 1, bit 0 of `INIT_VAL` or `XOR_VAL` is replicated to all `POLY_W` positions. When the flag is 0, the low `POLY_W` bits are used.
- R8: `in_ready` stays 0 from the acceptance of a subframe's final bit until the last checksum bit of that subframe has been loaded into the output register.
- R9: `out_last` is 1 only on the final checksum bit of a frame's last subframe. A frame ends after `NUM_SUB` subframes, or earlier at a subframe whose final bit arrived with `in_last`=1. An `in_last` on any other bit is ignored.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_bit` and `out_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block accepts the input bit this cycle |
| in_bit | input | 1 | Message bit |
| in_last | input | 1 | Frame end marker; honoured on a subframe's final bit |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Message or checksum bit |
| out_last | output | 1 | Final checksum bit of the frame |

## Verification
The bench builds three lanes. The first uses the defaults: a 16-bit checksum with the 0x1021 polynomial, zero-flush division, both reflections, and start value and mask given as a replicated scalar 1. Under these settings the flush cycles and the start-value term that separates the two division methods both show up in the results. The second lane uses a 3-bit polynomial x^3+x+1 with direct division, 5-bit subframes and two per frame, which reaches odd subframe lengths and very short checksums. The third lane uses an 8-bit checksum with direct division, three 24-bit subframes, input reflection, and a non-scalar start value and mask. Every lane sends a frame early end through `in_last`, stray `in_last` pulses, all-zero and all-one messages, and random backpressure on both sides.

// File: rtl/crc_app_pkg.sv
package crc_app_pkg;

  typedef enum logic [1:0] {
    PH_MSG,
    PH_FLUSH,
    PH_CHK
  } phase_t;

  function automatic int clog2_min1(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/crc_app_gather.sv
module crc_app_gather #(
  parameter int REFIN = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       bit_in,
  output logic       step_en,
  output logic       step_bit,
  output logic       byte_en,
  output logic [7:0] byte_out
);

  generate
    if (REFIN != 0) begin : g_reflect
      logic [2:0] pos;
      logic [6:0] hold;

      always_ff @(posedge clk) begin
        if (rst) begin
          pos  <= '0;
          hold <= '0;
        end else if (fire) begin
          pos  <= pos + 3'd1;
          hold <= {hold[5:0], bit_in};
        end
      end

      // Newest bit first, oldest bit last: byte_out[7] enters first.
      always_comb begin
        byte_out[7] = bit_in;
        for (int i = 0; i < 7; i++) begin
          byte_out[6 - i] = hold[i];
        end
      end

      assign byte_en  = fire && (pos == 3'd7);
      assign step_en  = 1'b0;
      assign step_bit = 1'b0;
    end else begin : g_straight
      assign step_en  = fire;
      assign step_bit = bit_in;
      assign byte_en  = 1'b0;
      assign byte_out = 8'h00;
    end
  endgenerate

endmodule

// File: rtl/crc_app_lfsr.sv
module crc_app_lfsr #(
  parameter int             W      = 16,
  parameter logic [W-1:0]   POLY   = '0,
  parameter logic [W-1:0]   INIT   = '0,
  parameter int             DIRECT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_init,
  input  logic         step_en,
  input  logic         step_bit,
  input  logic         byte_en,
  input  logic [7:0]   byte_in,
  output logic [W-1:0] crc_next
);

  logic [W-1:0] rem_q;

  function automatic logic [W-1:0] adv1(input logic [W-1:0] s, input logic b);
    logic         fb;
    logic [W-1:0] t;
    if (DIRECT != 0) begin
      fb = s[W-1] ^ b;
      t  = {s[W-2:0], 1'b0};
    end else begin
      fb = s[W-1];
      t  = {s[W-2:0], b};
    end
    return fb ? (t ^ POLY) : t;
  endfunction

  function automatic logic [W-1:0] adv8(input logic [W-1:0] s, input logic [7:0] v);
    logic [W-1:0] t;
    t = s;
    for (int i = 7; i >= 0; i--) begin
      t = adv1(t, v[i]);
    end
    return t;
  endfunction

  always_comb begin
    if (byte_en) begin
      crc_next = adv8(rem_q, byte_in);
    end else if (step_en) begin
      crc_next = adv1(rem_q, step_bit);
    end else begin
      crc_next = rem_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load_init) begin
      rem_q <= INIT;
    end else begin
      rem_q <= crc_next;
    end
  end

endmodule

// File: rtl/crc_app_finalize.sv
module crc_app_finalize #(
  parameter int           W        = 16,
  parameter int           REFOUT   = 1,
  parameter logic [W-1:0] XOR_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] crc_in,
  input  logic         shift,
  output logic         msb
);

  logic [W-1:0] mirrored;
  logic [W-1:0] folded;
  logic [W-1:0] sreg;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      mirrored[i] = crc_in[W-1-i];
    end
  end

  generate
    if (REFOUT != 0) begin : g_ref
      assign folded = mirrored ^ XOR_MASK;
    end else begin : g_noref
      assign folded = crc_in ^ XOR_MASK;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= folded;
    end else if (shift) begin
      sreg <= {sreg[W-2:0], 1'b0};
    end
  end

  assign msb = sreg[W-1];

endmodule

// File: rtl/serial_crc_appender.sv
module serial_crc_appender #(
  parameter int          POLY_W      = 16,
  parameter logic [31:0] POLY        = 32'h0000_1021,
  parameter logic [31:0] INIT_VAL    = 32'h1,
  parameter int          INIT_SCALAR = 1,
  parameter logic [31:0] XOR_VAL     = 32'h1,
  parameter int          XOR_SCALAR  = 1,
  parameter int          DIRECT      = 0,
  parameter int          REFIN       = 1,
  parameter int          REFOUT      = 1,
  parameter int          SUB_LEN     = 16,
  parameter int          NUM_SUB     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_last,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_last
);
  import crc_app_pkg::*;

  localparam logic [POLY_W-1:0] POLY_V = POLY[POLY_W-1:0];
  localparam logic [POLY_W-1:0] INIT_V =
    (INIT_SCALAR != 0) ? {POLY_W{INIT_VAL[0]}} : INIT_VAL[POLY_W-1:0];
  localparam logic [POLY_W-1:0] XOR_V =
    (XOR_SCALAR != 0) ? {POLY_W{XOR_VAL[0]}} : XOR_VAL[POLY_W-1:0];
  localparam int BCW = clog2_min1(SUB_LEN);
  localparam int SCW = clog2_min1(NUM_SUB);
  localparam int KW  = clog2_min1(POLY_W);

  phase_t           phase;
  logic [BCW-1:0]   bit_cnt;
  logic [SCW-1:0]   sub_cnt;
  logic [KW-1:0]    flush_cnt;
  logic [KW-1:0]    chk_cnt;
  logic             frame_end;

  logic             adv;
  logic             in_fire;
  logic             sub_done;
  logic             ends_frame;
  logic             flush_step;
  logic             flush_done;
  logic             crc_take;
  logic             g_step_en;
  logic             g_step_bit;
  logic             g_byte_en;
  logic [7:0]       g_byte;
  logic [POLY_W-1:0] crc_next;
  logic             fin_msb;

  assign adv        = !out_valid || out_ready;
  assign in_ready   = (phase == PH_MSG) && adv;
  assign in_fire    = in_valid && in_ready;
  assign sub_done   = in_fire && (bit_cnt == BCW'(SUB_LEN - 1));
  assign ends_frame = (sub_cnt == SCW'(NUM_SUB - 1)) || in_last;
  assign flush_step = (phase == PH_FLUSH);
  assign flush_done = flush_step && (flush_cnt == KW'(POLY_W - 1));
  assign crc_take   = (DIRECT != 0) ? sub_done : flush_done;

  crc_app_gather #(
    .REFIN (REFIN)
  ) u_gather (
    .clk      (clk),
    .rst      (rst),
    .fire     (in_fire),
    .bit_in   (in_bit),
    .step_en  (g_step_en),
    .step_bit (g_step_bit),
    .byte_en  (g_byte_en),
    .byte_out (g_byte)
  );

  crc_app_lfsr #(
    .W      (POLY_W),
    .POLY   (POLY_V),
    .INIT   (INIT_V),
    .DIRECT (DIRECT)
  ) u_lfsr (
    .clk       (clk),
    .rst       (rst),
    .load_init (crc_take),
    .step_en   (g_step_en || flush_step),
    .step_bit  (g_step_bit && !flush_step),
    .byte_en   (g_byte_en),
    .byte_in   (g_byte),
    .crc_next  (crc_next)
  );

  crc_app_finalize #(
    .W        (POLY_W),
    .REFOUT   (REFOUT),
    .XOR_MASK (XOR_V)
  ) u_final (
    .clk    (clk),
    .rst    (rst),
    .load   (crc_take),
    .crc_in (crc_next),
    .shift  ((phase == PH_CHK) && adv),
    .msb    (fin_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_MSG;
      bit_cnt   <= '0;
      sub_cnt   <= '0;
      flush_cnt <= '0;
      chk_cnt   <= '0;
      frame_end <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      case (phase)
        PH_MSG: begin
          if (in_fire) begin
            out_bit   <= in_bit;
            out_valid <= 1'b1;
            out_last  <= 1'b0;
            if (sub_done) begin
              bit_cnt   <= '0;
              frame_end <= ends_frame;
              sub_cnt   <= ends_frame ? '0 : sub_cnt + 1'b1;
              phase     <= (DIRECT != 0) ? PH_CHK : PH_FLUSH;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end else if (out_ready) begin
            out_valid <= 1'b0;
          end
        end
        PH_FLUSH: begin
          if (out_ready) begin
            out_valid <= 1'b0;
          end
          if (flush_done) begin
            flush_cnt <= '0;
            phase     <= PH_CHK;
          end else begin
            flush_cnt <= flush_cnt + 1'b1;
          end
        end
        PH_CHK: begin
          if (adv) begin
            out_bit   <= fin_msb;
            out_valid <= 1'b1;
            out_last  <= frame_end && (chk_cnt == KW'(POLY_W - 1));
            if (chk_cnt == KW'(POLY_W - 1)) begin
              chk_cnt <= '0;
              phase   <= PH_MSG;
            end else begin
              chk_cnt <= chk_cnt + 1'b1;
            end
          end
        end
        default: phase <= PH_MSG;
      endcase
    end
  end

endmodule

// File: rtl/serial_crc_appender_checker.sv
module serial_crc_appender_checker #(
  parameter int SUB_LEN = 16,
  parameter int W       = 16
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_last
);

  int   out_k;
  logic was_rst;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst) begin
      out_k <= 0;
    end else if (out_valid && out_ready) begin
      out_k <= (out_k == SUB_LEN + W - 1) ? 0 : out_k + 1;
    end
  end

  always_ff @(posedge clk) begin
    if (was_rst) begin
      AST_RESET_IDLE: assert (!out_valid && !out_last); // R1
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last))); // R10

  AST_NO_INPUT_IN_CHECKSUM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (out_k < SUB_LEN || out_k == SUB_LEN + W - 1)); // R8

  AST_LAST_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (out_k == SUB_LEN + W - 1)); // R9

endmodule

bind serial_crc_appender serial_crc_appender_checker #(
  .SUB_LEN (SUB_LEN),
  .W       (POLY_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .out_last  (out_last)
);

// File: tb/serial_crc_appender_lane.sv
module serial_crc_appender_lane #(
  parameter int          POLY_W      = 16,
  parameter logic [31:0] POLY        = 32'h0000_1021,
  parameter logic [31:0] INIT_VAL    = 32'h1,
  parameter int          INIT_SCALAR = 1,
  parameter logic [31:0] XOR_VAL     = 32'h1,
  parameter int          XOR_SCALAR  = 1,
  parameter int          DIRECT      = 0,
  parameter int          REFIN       = 1,
  parameter int          REFOUT      = 1,
  parameter int          SUB_LEN     = 16,
  parameter int          NUM_SUB     = 2,
  parameter int          FRAMES      = 12,
  parameter string       TAG         = "R3"
) (
  input  logic clk,
  input  logic rst,
  output logic done
);

  logic in_valid, in_ready, in_bit, in_last;
  logic out_valid, out_ready, out_bit, out_last;

  integer checks = 0;
  integer fails  = 0;

  logic [POLY_W-1:0] init_v, xor_v;
  bit in_q[$];
  bit lst_q[$];
  bit exp_q[$];
  bit expl_q[$];
  bit expc_q[$];

  serial_crc_appender #(
    .POLY_W      (POLY_W),
    .POLY        (POLY),
    .INIT_VAL    (INIT_VAL),
    .INIT_SCALAR (INIT_SCALAR),
    .XOR_VAL     (XOR_VAL),
    .XOR_SCALAR  (XOR_SCALAR),
    .DIRECT      (DIRECT),
    .REFIN       (REFIN),
    .REFOUT      (REFOUT),
    .SUB_LEN     (SUB_LEN),
    .NUM_SUB     (NUM_SUB)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_last  (out_last)
  );

  // Polynomial long division of a bit list (highest power first) by x^W + POLY.
  function automatic logic [POLY_W-1:0] divrem(input bit q[$]);
    logic [POLY_W:0] r;
    r = '0;
    foreach (q[i]) begin
      r = {r[POLY_W-1:0], q[i]};
      if (r[POLY_W]) r = r ^ {1'b1, POLY[POLY_W-1:0]};
    end
    return r[POLY_W-1:0];
  endfunction

  task automatic check(input string tag, input logic act, input logic expv);
    checks = checks + 1;
    if (act !== expv) begin
      fails = fails + 1;
      $display("FAIL %s lane %s: got %0b expected %0b at %0t", tag, TAG, act, expv, $time);
    end
  endtask

  task automatic build();
    for (int f = 0; f < FRAMES; f++) begin
      int k;
      k = 1 + int'($urandom % NUM_SUB);
      for (int s = 0; s < k; s++) begin
        bit msg[$];
        bit da[$];
        bit db[$];
        logic [POLY_W-1:0] rm, ck;
        bit b;
        for (int i = 0; i < SUB_LEN; i++) begin
          if (f % 4 == 0)      b = 1'b0;
          else if (f % 4 == 1) b = 1'b1;
          else                 b = bit'($urandom % 2);
          msg.push_back(b);
        end
        // start value term, R7 replicated or taken whole
        for (int j = POLY_W - 1; j >= 0; j--) da.push_back(init_v[j]);
        for (int i = 0; i < ((DIRECT != 0) ? SUB_LEN : SUB_LEN + POLY_W); i++) da.push_back(1'b0);
        // message term, byte reflected per R5
        for (int i = 0; i < SUB_LEN; i++)
          db.push_back((REFIN != 0) ? msg[(i / 8) * 8 + 7 - (i % 8)] : msg[i]);
        for (int i = 0; i < POLY_W; i++) db.push_back(1'b0);
        rm = divrem(da) ^ divrem(db);
        if (REFOUT != 0) begin
          for (int j = 0; j < POLY_W; j++) ck[j] = rm[POLY_W - 1 - j];
        end else begin
          ck = rm;
        end
        ck = ck ^ xor_v;
        for (int i = 0; i < SUB_LEN; i++) begin
          in_q.push_back(msg[i]);
          if (i == SUB_LEN - 1) lst_q.push_back(s == k - 1);
          else                  lst_q.push_back(($urandom % 8) == 0);
          exp_q.push_back(msg[i]);
          expl_q.push_back(1'b0);
          expc_q.push_back(1'b0);
        end
        for (int j = POLY_W - 1; j >= 0; j--) begin
          exp_q.push_back(ck[j]);
          expl_q.push_back((j == 0) && (s == k - 1));
          expc_q.push_back(1'b1);
        end
      end
    end
  endtask

  initial begin
    int tot_in;
    int tot_out;
    bit pv_hold;
    logic pv_bit, pv_last;
    tot_in  = 0;
    tot_out = 0;
    pv_hold = 0;
    pv_bit  = 0;
    pv_last = 0;
    done      = 1'b0;
    in_valid  = 1'b0;
    in_bit    = 1'b0;
    in_last   = 1'b0;
    out_ready = 1'b0;
    init_v = (INIT_SCALAR != 0) ? {POLY_W{INIT_VAL[0]}} : INIT_VAL[POLY_W-1:0];
    xor_v  = (XOR_SCALAR != 0) ? {POLY_W{XOR_VAL[0]}} : XOR_VAL[POLY_W-1:0];
    build();
    wait (rst == 1'b0);
    @(negedge clk);
    #1;
    // R1: idle after reset
    check("R1 out_valid", out_valid, 1'b0);
    check("R1 out_last", out_last, 1'b0);
    check("R1 in_ready", in_ready, 1'b1);
    while (exp_q.size() > 0) begin
      @(negedge clk);
      if (pv_hold) begin
        check("R10 valid held", out_valid, 1'b1);
        check("R10 bit held", out_bit, pv_bit);
        check("R10 last held", out_last, pv_last);
      end
      in_valid = (in_q.size() > 0) && (($urandom % 4) != 0);
      in_bit   = in_valid ? in_q[0] : 1'b0;
      in_last  = in_valid ? lst_q[0] : 1'b0;
      out_ready = (($urandom % 3) != 0);
      #1;
      if (tot_in > 0 && (tot_in % SUB_LEN) == 0 &&
          tot_out < (tot_in / SUB_LEN) * (SUB_LEN + POLY_W) - 1)
        check("R8 in_ready stall", in_ready, 1'b0);
      if (in_valid && in_ready) begin
        void'(in_q.pop_front());
        void'(lst_q.pop_front());
        tot_in++;
      end
      pv_hold = out_valid && !out_ready;
      pv_bit  = out_bit;
      pv_last = out_last;
      if (out_valid && out_ready) begin
        if (expc_q[0]) check(TAG, out_bit, exp_q[0]);
        else           check("R2 message bit", out_bit, exp_q[0]);
        check("R9 out_last", out_last, expl_q[0]);
        void'(exp_q.pop_front());
        void'(expl_q.pop_front());
        void'(expc_q.pop_front());
        tot_out++;
      end
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    check("R2 no extra bits", out_valid, 1'b0);
    done = 1'b1;
  end

endmodule

// File: tb/serial_crc_appender_test.sv
module serial_crc_appender_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_a, done_b, done_c;

  always #4 clk = ~clk;

  serial_crc_appender_lane #(
    .FRAMES (12),
    .TAG    ("R3/R5/R6/R7 checksum")
  ) lane_a (
    .clk  (clk),
    .rst  (rst),
    .done (done_a)
  );

  serial_crc_appender_lane #(
    .POLY_W      (3),
    .POLY        (32'h3),
    .INIT_VAL    (32'h0),
    .INIT_SCALAR (1),
    .XOR_VAL     (32'h0),
    .XOR_SCALAR  (1),
    .DIRECT      (1),
    .REFIN       (0),
    .REFOUT      (0),
    .SUB_LEN     (5),
    .NUM_SUB     (2),
    .FRAMES      (16),
    .TAG         ("R4 checksum")
  ) lane_b (
    .clk  (clk),
    .rst  (rst),
    .done (done_b)
  );

  serial_crc_appender_lane #(
    .POLY_W      (8),
    .POLY        (32'h07),
    .INIT_VAL    (32'hA5),
    .INIT_SCALAR (0),
    .XOR_VAL     (32'h3C),
    .XOR_SCALAR  (0),
    .DIRECT      (1),
    .REFIN       (1),
    .REFOUT      (0),
    .SUB_LEN     (24),
    .NUM_SUB     (3),
    .FRAMES      (10),
    .TAG         ("R4/R5/R6/R7 checksum")
  ) lane_c (
    .clk  (clk),
    .rst  (rst),
    .done (done_c)
  );

  initial begin
    int cyc;
    int total;
    int bad;
    cyc = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    while (!(done_a && done_b && done_c) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    total = lane_a.checks + lane_b.checks + lane_c.checks;
    bad   = lane_a.fails + lane_b.fails + lane_c.fails;
    if (!(done_a && done_b && done_c)) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", total, bad);
    $finish;
  end

endmodule